// File: doc/BRIEF.md
# Countdown Alarm with Interrupt

This block is the relative alarm of a real-time clock. Software loads an interval of days, hours, minutes and seconds into one register word. While counting is enabled, every one-hertz tick takes one second off the interval, with borrows carried up through the fields. The tick that brings the interval to zero sets a sticky pending flag. The interval then stays at zero. An interrupt line follows the pending flag, gated by an interrupt enable.

Software reaches the block through a simple word-wide register bus. It has separate write and read strobes, a byte offset, and read data that is registered. Counting enable, interrupt enable and pending status each have their own register. The pending flag is cleared by writing one to it.

Top module: `alarm_countdown`

## Requirements
- R1: After a synchronous reset the interval, counting enable, interrupt enable, pending flag, read data and irq are all zero.
- R2: The interval register sits at offset 0x0C. It holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days in bits 28:21. A write loads all four fields, and every other bit reads as zero.
- R3: Counting enable is bit 8 at offset 0x14, and interrupt enable is bit 0 at offset 0x18. Both read back as written, and all other bits of those registers read as zero.
- R4: While counting enable is 0, ticks leave the interval unchanged.
- R5: Each tick with counting enabled and a nonzero interval subtracts one second. A zero seconds field becomes 59 and borrows a minute. A zero minutes field becomes 59 and borrows an hour. A zero hours field becomes 23 and borrows a day.
- R6: The tick that brings the interval to zero sets the pending flag (bit 0 at offset 0x1C) on the same clock edge. The interval then stays zero under further ticks and is not reloaded.
- R7: With counting enabled and an interval of zero, ticks change nothing and do not set the pending flag.
- R8: Writing 1 to bit 0 at offset 0x1C clears the pending flag, and writing 0 there has no effect. If a clear and an expiry fall in the same cycle, the flag ends up set.
- R9: irq is a register equal to the pending flag AND the interrupt enable. It changes on the same edge as either of them.
- R10: An interval write in the same cycle as a tick loads the written value, and that tick is discarded.
- R11: Read data for a read strobe appears on the next clock edge and holds until the next read. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Alarm interrupt |

## Verification
Every result is due one edge after its stimulus:
- a tick updates the interval, the pending flag and irq on the edge that samples it;
- a write updates the control registers and irq on its own edge;
- read data lands on the edge after the strobe.

The bench drives each stimulus for exactly one cycle, starting at a falling edge, and samples on the next falling edge. So every check lands half a period after the edge that produced the result. The same-cycle cases drive both stimuli in the same half cycle so that they share one edge: clear against expiry, and load against tick.

// File: rtl/alarm_cd_pkg.sv
package alarm_cd_pkg;
  // field geometry of the interval word
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HR_W    = 5;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;
  localparam int SEC_MAX = 59;
  localparam int MIN_MAX = 59;
  localparam int HR_MAX  = 23;

  // control bit positions
  localparam int RUN_BIT  = 8;
  localparam int IRQE_BIT = 0;
  localparam int FLAG_BIT = 0;

  // byte offsets
  localparam int OFS_SPAN = 'h0C;
  localparam int OFS_RUN  = 'h14;
  localparam int OFS_IRQE = 'h18;
  localparam int OFS_FLAG = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SPAN,
    SEL_RUN,
    SEL_IRQE,
    SEL_FLAG
  } reg_sel_e;
endpackage

// File: rtl/alarm_cd_stage.sv
module alarm_cd_stage #(
  parameter int W    = 6,
  parameter int MAXV = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_in,
  output logic [W-1:0] val,
  output logic         borrow_out
);
  logic [W-1:0] q;

  assign borrow_out = dec_in && (q == '0);
  assign val        = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (dec_in) begin
      if (q == '0) q <= W'(MAXV);
      else         q <= q - 1'b1;
    end
  end
endmodule

// File: rtl/alarm_cd_regs.sv
module alarm_cd_regs
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] span_word,
  input  logic              expire,
  output logic              span_load,
  output logic              run_en,
  output logic              irq_en,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] bus_rdata
);
  reg_sel_e    sel;
  logic        run_d, irqe_d, flag_d, clr;
  logic [DATA_W-1:0] rd_mux;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_SPAN): sel = SEL_SPAN;
      ADDR_W'(OFS_RUN):  sel = SEL_RUN;
      ADDR_W'(OFS_IRQE): sel = SEL_IRQE;
      ADDR_W'(OFS_FLAG): sel = SEL_FLAG;
      default:           sel = SEL_NONE;
    endcase
  end

  assign span_load = bus_wr && (sel == SEL_SPAN);
  assign clr       = bus_wr && (sel == SEL_FLAG) && bus_wdata[FLAG_BIT];

  always_comb begin
    run_d  = run_en;
    irqe_d = irq_en;
    if (bus_wr && sel == SEL_RUN)  run_d  = bus_wdata[RUN_BIT];
    if (bus_wr && sel == SEL_IRQE) irqe_d = bus_wdata[IRQE_BIT];
    // expiry takes precedence over a clear in the same cycle
    flag_d = expire || (flag && !clr);
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_SPAN: rd_mux = span_word;
      SEL_RUN:  rd_mux[RUN_BIT]  = run_en;
      SEL_IRQE: rd_mux[IRQE_BIT] = irq_en;
      SEL_FLAG: rd_mux[FLAG_BIT] = flag;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      irq_en    <= 1'b0;
      flag      <= 1'b0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      run_en <= run_d;
      irq_en <= irqe_d;
      flag   <= flag_d;
      irq    <= flag_d && irqe_d;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int DAY_MAX = (1 << DAY_W) - 1;

  logic              span_load, run_en, irq_en, flag;
  logic              dec, expire, span_nz;
  logic              b_sec, b_min, b_hr, b_day;
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [HR_W-1:0]   hr_q;
  logic [DAY_W-1:0]  day_q;
  logic [DATA_W-1:0] span_word;

  always_comb begin
    span_word = '0;
    span_word[SEC_LSB +: SEC_W] = sec_q;
    span_word[MIN_LSB +: MIN_W] = min_q;
    span_word[HR_LSB  +: HR_W]  = hr_q;
    span_word[DAY_LSB +: DAY_W] = day_q;
  end

  assign span_nz = |span_word;
  assign dec     = run_en && tick_1hz && !span_load && span_nz;
  assign expire  = dec && (span_word == DATA_W'(1));

  alarm_cd_stage #(.W(SEC_W), .MAXV(SEC_MAX)) u_sec (
    .clk(clk), .rst(rst), .load(span_load),
    .load_val(bus_wdata[SEC_LSB +: SEC_W]),
    .dec_in(dec), .val(sec_q), .borrow_out(b_sec));

  alarm_cd_stage #(.W(MIN_W), .MAXV(MIN_MAX)) u_min (
    .clk(clk), .rst(rst), .load(span_load),
    .load_val(bus_wdata[MIN_LSB +: MIN_W]),
    .dec_in(b_sec), .val(min_q), .borrow_out(b_min));

  alarm_cd_stage #(.W(HR_W), .MAXV(HR_MAX)) u_hr (
    .clk(clk), .rst(rst), .load(span_load),
    .load_val(bus_wdata[HR_LSB +: HR_W]),
    .dec_in(b_min), .val(hr_q), .borrow_out(b_hr));

  alarm_cd_stage #(.W(DAY_W), .MAXV(DAY_MAX)) u_day (
    .clk(clk), .rst(rst), .load(span_load),
    .load_val(bus_wdata[DAY_LSB +: DAY_W]),
    .dec_in(b_hr), .val(day_q), .borrow_out(b_day));

  logic unused_borrow;
  assign unused_borrow = b_day;

  alarm_cd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .span_word(span_word), .expire(expire),
    .span_load(span_load), .run_en(run_en), .irq_en(irq_en),
    .flag(flag), .irq(irq), .bus_rdata(bus_rdata));
endmodule

// File: rtl/alarm_countdown_checker.sv
module alarm_countdown_checker
  import alarm_cd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DAY_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_1hz,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] span_word,
  input logic              run_en,
  input logic              irq_en,
  input logic              flag,
  input logic              irq
);
  localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'((1 << DAY_W) - 1) << DAY_LSB) |
      (DATA_W'((1 << HR_W) - 1)  << HR_LSB)  |
      (DATA_W'((1 << MIN_W) - 1) << MIN_LSB) |
      (DATA_W'((1 << SEC_W) - 1) << SEC_LSB);

  logic ld, clr, hit;
  assign ld  = bus_wr && (bus_addr == ADDR_W'(OFS_SPAN));
  assign clr = bus_wr && (bus_addr == ADDR_W'(OFS_FLAG)) && bus_wdata[FLAG_BIT];
  assign hit = run_en && tick_1hz && !ld && (span_word == DATA_W'(1));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && irq_en));

  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !ld) |=> $stable(span_word));

  p_zero_stays_r7: assert property (@(posedge clk) disable iff (rst)
    ((span_word == '0) && !ld && !flag && !clr) |=> ((span_word == '0) && !flag));

  p_expiry_sets_r6: assert property (@(posedge clk) disable iff (rst)
    hit |=> (flag && (span_word == '0)));

  p_clear_works_r8: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  p_load_value_r10: assert property (@(posedge clk) disable iff (rst)
    ld |=> (span_word == ($past(bus_wdata) & FIELD_MASK)));
endmodule

bind alarm_countdown alarm_countdown_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W)
) u_checker (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .span_word(span_word),
  .run_en(run_en), .irq_en(irq_en), .flag(flag), .irq(irq));

// File: tb/alarm_countdown_bench.sv
module alarm_countdown_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SPAN = 8'h0C, A_RUN = 8'h14, A_IRQE = 8'h18, A_FLAG = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1hz = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_countdown u_alarm_countdown (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    return (32'(d) << 21) | (32'(h) << 16) | (32'(m) << 8) | 32'(s);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_SPAN, v); check("R1 span", v, 32'h0);
    rd(A_RUN, v);  check("R1 run", v, 32'h0);
    rd(A_IRQE, v); check("R1 irqe", v, 32'h0);
    rd(A_FLAG, v); check("R1 flag", v, 32'h0);
  endtask

  task automatic t_layout();
    logic [31:0] v;
    wr(A_SPAN, 32'hFFFF_FFFF);
    rd(A_SPAN, v); check("R2 all ones masked", v, 32'h1FFF_3F3F);
    wr(A_SPAN, pack(200, 13, 45, 7));
    rd(A_SPAN, v); check("R2 field placement", v, pack(200, 13, 45, 7));
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(A_RUN, 32'hFFFF_FFFF);  rd(A_RUN, v);  check("R3 run bit", v, 32'h100);
    wr(A_IRQE, 32'hFFFF_FFFF); rd(A_IRQE, v); check("R3 irqe bit", v, 32'h1);
    wr(A_RUN, 32'h0);  rd(A_RUN, v);  check("R3 run clear", v, 32'h0);
    wr(A_IRQE, 32'h0); rd(A_IRQE, v); check("R3 irqe clear", v, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(A_SPAN, pack(0, 0, 0, 5));
    ticks(3);
    rd(A_SPAN, v); check("R4 no count when off", v, pack(0, 0, 0, 5));
  endtask

  task automatic t_borrow();
    logic [31:0] v;
    wr(A_RUN, 32'h100);
    wr(A_SPAN, pack(1, 0, 0, 0)); ticks(1);
    rd(A_SPAN, v); check("R5 day borrow", v, pack(0, 23, 59, 59));
    wr(A_SPAN, pack(0, 1, 0, 0)); ticks(1);
    rd(A_SPAN, v); check("R5 hour borrow", v, pack(0, 0, 59, 59));
    wr(A_SPAN, pack(0, 0, 1, 0)); ticks(1);
    rd(A_SPAN, v); check("R5 minute borrow", v, pack(0, 0, 0, 59));
    wr(A_SPAN, pack(0, 0, 0, 3)); ticks(2);
    rd(A_SPAN, v); check("R5 plain seconds", v, pack(0, 0, 0, 1));
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(A_IRQE, 32'h0);
    wr(A_SPAN, pack(0, 0, 0, 2));
    wr(A_RUN, 32'h100);
    ticks(1);
    rd(A_FLAG, v); check("R6 not yet pending", v, 32'h0);
    tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0;
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    rd(A_FLAG, v); check("R6 pending at zero", v, 32'h1);
    wr(A_IRQE, 32'h1);
    check("R9 irq on enable", {31'b0, irq}, 32'h1);
    ticks(3);
    rd(A_SPAN, v); check("R6 stays zero", v, 32'h0);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); check("R8 write zero keeps flag", v, 32'h1);
    wr(A_IRQE, 32'h0);
    check("R9 irq drops with enable", {31'b0, irq}, 32'h0);
    wr(A_IRQE, 32'h1);
    wr(A_FLAG, 32'h1);
    check("R9 irq drops with clear", {31'b0, irq}, 32'h0);
    rd(A_FLAG, v); check("R8 clear", v, 32'h0);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    wr(A_SPAN, 32'h0);
    wr(A_RUN, 32'h100);
    wr(A_IRQE, 32'h1);
    ticks(4);
    rd(A_FLAG, v); check("R7 zero interval idle", v, 32'h0);
    check("R7 no irq", {31'b0, irq}, 32'h0);
    rd(A_SPAN, v); check("R7 interval still zero", v, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(A_SPAN, pack(0, 0, 0, 1));
    // clear and expiry on the same edge
    bus_wr = 1'b1; bus_addr = A_FLAG; bus_wdata = 32'h1; tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; tick_1hz = 1'b0;
    rd(A_FLAG, v); check("R8 expiry beats clear", v, 32'h1);
    check("R9 irq after race", {31'b0, irq}, 32'h1);
    wr(A_FLAG, 32'h1);
  endtask

  task automatic t_load_tick();
    logic [31:0] v;
    wr(A_SPAN, pack(0, 0, 0, 9));
    bus_wr = 1'b1; bus_addr = A_SPAN; bus_wdata = pack(0, 0, 2, 0); tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; tick_1hz = 1'b0;
    rd(A_SPAN, v); check("R10 load beats tick", v, pack(0, 0, 2, 0));
    wr(A_RUN, 32'h0);
  endtask

  task automatic t_read_path();
    logic [31:0] v;
    wr(A_SPAN, pack(3, 4, 5, 6));
    rd(A_SPAN, v); check("R11 read latency", v, pack(3, 4, 5, 6));
    @(negedge clk);
    check("R11 rdata holds", bus_rdata, pack(3, 4, 5, 6));
    rd(8'h10, v); check("R11 unmapped 0x10", v, 32'h0);
    rd(8'h00, v); check("R11 unmapped 0x00", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_ctrl();
    t_disabled();
    t_borrow();
    t_expire();
    t_idle();
    t_race();
    t_load_tick();
    t_read_path();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule